// File: doc/BRIEF.md
# Memory-to-Stream DMA Read Channel

This block is a single-direction DMA channel working in direct (non-descriptor) mode. A processor programs it through a small register window: it sets the run bit, writes a source byte address, and then writes a byte count. The write of the byte count launches the transfer. The channel then fetches the buffer one byte at a time over a simple request/response memory port and delivers each byte as one beat on a valid/ready output stream. The final byte carries an end-of-packet marker.

Software tracks progress in two ways. It can poll a status word that reports halted, idle, a completion flag and an error flag. It can also wait on one interrupt line. Both flags are cleared by writing 1 to them. A self-clearing soft reset returns the channel to its power-up state. The register window is 0x30 bytes wide, so a second channel placed at offset 0x30 can share the same register port.

On the output stream, `st_valid` stays high with `st_data` and `st_last` unchanged until a cycle in which `st_ready` is high; that cycle completes the beat. `st_ready` may be held low for any number of cycles. On the memory side, `mem_req` stays high with `mem_addr` unchanged until `mem_gnt` is high. Exactly one response (`mem_rvalid`, with `mem_rdata` and `mem_rerr`) must follow each grant, one or more cycles later. Only one request is outstanding at a time.

Top module: `rd_dma_chan`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0. The status word (offset 0x04) reads 0x3, meaning halted (bit 0) and idle (bit 1). `irq` is low, and neither `st_valid` nor `mem_req` is asserted.
- R2: Control bit 0 is run. Writing 1 clears status bit 0. Writing 0 sets status bit 0 and aborts any transfer in progress: no further beats are sent and the channel returns to idle.
- R3: While running and idle, a write to the length register (offset 0x28) with a value N starts a transfer. The transfer emits N beats carrying the bytes at ascending addresses, beginning at the source address held at offset 0x18.
- R4: `st_last` is high on the N-th beat only. Completion flag status bit 12 is set once that beat is accepted. Status bit 1 is 0 while a transfer is in progress and 1 otherwise.
- R5: A stream beat that is held off holds its valid, data and last values. A memory request that is not granted holds its request and its address.
- R6: Writing 1 to status bit 12 or bit 14 clears only that flag, and 0 bits have no effect. A flag being set by hardware in the same cycle as a clear wins over the clear.
- R7: `irq` = (status bit 12 AND control bit 12) OR (status bit 14 AND control bit 14).
- R8: A length write of 0, or of a value with any bit at or above LEN_W set (default 26), starts no transfer and sets error flag status bit 14.
- R9: A length write while halted or while a transfer is in progress is ignored. No beats result, and offset 0x28 keeps the last accepted length.
- R10: A memory response with `mem_rerr` high sets status bit 14 and ends the transfer. The faulty byte is not sent, `st_last` is never asserted, and the channel returns to idle.
- R11: Writing control bit 2 starts a soft reset. Control bit 2 reads 1 until the reset has finished. Afterwards, control, source, length and both flags read 0 and the status word reads 0x3.
- R12: Offsets other than 0x00, 0x04, 0x18 and 0x28 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 8 | Read response byte |
| mem_rerr | input | 1 | Read response carries a fault |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Downstream accepts the beat |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final beat of the transfer |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sequencer state appears at the ports within one or two cycles. A channel stuck busy leaves status bit 1 at 0 forever. A wrong byte counter shows up as a beat count that is off by one, or as `st_last` on the wrong beat. A wrong address register shows up as data that does not match the memory pattern at the first mismatching beat. If a flag register takes the wrong value, the next status read or `irq` shows it in the following cycle. A soft reset or abort that fails to drain a pending memory response shows up as a stray beat or a stuck busy state on the next transfer. The directed scenarios therefore read the status word and count beats right after each event instead of only at the end of the run.

// File: rtl/rd_dma_pkg.sv
package rd_dma_pkg;

  // Register byte offsets inside the channel window
  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_SRC  = 6'h18;
  localparam logic [5:0] OFS_LEN  = 6'h28;

  // Control bit positions
  localparam int CB_RUN     = 0;
  localparam int CB_SRST    = 2;
  localparam int CB_DONE_IE = 12;
  localparam int CB_ERR_IE  = 14;

  // Status bit positions
  localparam int SB_HALT = 0;
  localparam int SB_IDLE = 1;
  localparam int SB_DONE = 12;
  localparam int SB_ERR  = 14;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_REQ,
    FS_WAIT,
    FS_SEND,
    FS_FLUSH
  } fetch_state_e;

  typedef struct packed {
    logic err_ie;
    logic done_ie;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/rd_dma_regs.sv
module rd_dma_regs
  import rd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 26,
  parameter int REG_AW = 6,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              fetch_idle,
  input  logic              done_set,
  input  logic              err_set,
  output ctrl_t             ctrl,
  output logic              srst,
  output logic              start,
  output logic [ADDR_W-1:0] src,
  output logic [LEN_W-1:0]  len,
  output logic              done_flag,
  output logic              err_flag
);

  logic wr_ctrl, wr_stat, wr_src, wr_len;
  logic len_try, len_bad;
  logic clr_done, clr_err;

  assign wr_ctrl = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
  assign wr_stat = reg_we && (reg_addr == REG_AW'(OFS_STAT));
  assign wr_src  = reg_we && (reg_addr == REG_AW'(OFS_SRC));
  assign wr_len  = reg_we && (reg_addr == REG_AW'(OFS_LEN));

  // A length write only counts while running, idle and not resetting
  assign len_try = wr_len && ctrl.run && fetch_idle && !srst;
  assign len_bad = len_try && ((reg_wdata == '0) || (|(reg_wdata >> LEN_W)));
  assign start   = len_try && !len_bad;

  assign clr_done = wr_stat && reg_wdata[SB_DONE];
  assign clr_err  = wr_stat && reg_wdata[SB_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      srst      <= 1'b0;
      src       <= '0;
      len       <= '0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else if (srst) begin
      ctrl      <= '0;
      src       <= '0;
      len       <= '0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      if (fetch_idle) srst <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        if (reg_wdata[CB_SRST]) begin
          srst <= 1'b1;
        end else begin
          ctrl.run     <= reg_wdata[CB_RUN];
          ctrl.done_ie <= reg_wdata[CB_DONE_IE];
          ctrl.err_ie  <= reg_wdata[CB_ERR_IE];
        end
      end
      if (wr_src) src <= reg_wdata[ADDR_W-1:0];
      if (start)  len <= reg_wdata[LEN_W-1:0];
      // hardware set wins over a same-cycle clear
      done_flag <= (done_flag && !clr_done) || done_set;
      err_flag  <= (err_flag && !clr_err) || err_set || len_bad;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_AW'(OFS_CTRL): begin
        reg_rdata[CB_RUN]     = ctrl.run;
        reg_rdata[CB_SRST]    = srst;
        reg_rdata[CB_DONE_IE] = ctrl.done_ie;
        reg_rdata[CB_ERR_IE]  = ctrl.err_ie;
      end
      REG_AW'(OFS_STAT): begin
        reg_rdata[SB_HALT] = !ctrl.run;
        reg_rdata[SB_IDLE] = fetch_idle;
        reg_rdata[SB_DONE] = done_flag;
        reg_rdata[SB_ERR]  = err_flag;
      end
      REG_AW'(OFS_SRC): reg_rdata = BUS_W'(src);
      REG_AW'(OFS_LEN): reg_rdata = BUS_W'(len);
      default:          reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rd_dma_fetch.sv
module rd_dma_fetch
  import rd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 26,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [LEN_W-1:0]  start_len,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [BYTE_W-1:0] st_data,
  output logic              st_last,
  output logic              idle,
  output logic              done_set,
  output logic              err_set
);

  fetch_state_e             state;
  logic [ADDR_W-1:0]        cur;
  logic [LEN_W-1:0]         remain;
  logic [BYTE_W-1:0]        hold;
  logic                     final_beat;

  assign final_beat = (remain == LEN_W'(1));
  assign mem_req    = (state == FS_REQ);
  assign mem_addr   = cur;
  assign st_valid   = (state == FS_SEND);
  assign st_data    = hold;
  assign st_last    = st_valid && final_beat;
  assign idle       = (state == FS_IDLE);
  assign done_set   = st_valid && st_ready && final_beat;
  assign err_set    = (state == FS_WAIT) && mem_rvalid && mem_rerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      cur    <= '0;
      remain <= '0;
      hold   <= '0;
    end else begin
      unique case (state)
        FS_IDLE: begin
          if (start && !abort) begin
            cur    <= start_src;
            remain <= start_len;
            state  <= FS_REQ;
          end
        end
        FS_REQ: begin
          // a granted request owes a response, so drain it on abort
          if (abort)        state <= mem_gnt ? FS_FLUSH : FS_IDLE;
          else if (mem_gnt) state <= FS_WAIT;
        end
        FS_WAIT: begin
          if (mem_rvalid) begin
            if (mem_rerr || abort) begin
              state <= FS_IDLE;
            end else begin
              hold  <= mem_rdata;
              state <= FS_SEND;
            end
          end else if (abort) begin
            state <= FS_FLUSH;
          end
        end
        FS_SEND: begin
          // an accepted beat completes even in the abort cycle
          if (st_ready) begin
            if (final_beat || abort) begin
              state <= FS_IDLE;
            end else begin
              cur    <= cur + ADDR_W'(1);
              remain <= remain - LEN_W'(1);
              state  <= FS_REQ;
            end
          end else if (abort) begin
            state <= FS_IDLE;
          end
        end
        FS_FLUSH: begin
          if (mem_rvalid) state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rd_dma_chan.sv
module rd_dma_chan
  import rd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rerr,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [7:0]        st_data,
  output logic              st_last,
  output logic              irq
);

  localparam int REG_AW = 6;
  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;

  ctrl_t             ctrl;
  logic              srst;
  logic              start;
  logic [ADDR_W-1:0] src;
  logic [LEN_W-1:0]  len;
  logic              done_flag, err_flag;
  logic              fetch_idle, done_set, err_set;
  logic              abort;

  assign abort = !ctrl.run || srst;
  assign irq   = (done_flag && ctrl.done_ie) || (err_flag && ctrl.err_ie);

  rd_dma_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_AW(REG_AW), .BUS_W(BUS_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .fetch_idle (fetch_idle),
    .done_set   (done_set),
    .err_set    (err_set),
    .ctrl       (ctrl),
    .srst       (srst),
    .start      (start),
    .src        (src),
    .len        (len),
    .done_flag  (done_flag),
    .err_flag   (err_flag)
  );

  rd_dma_fetch #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (abort),
    .start      (start),
    .start_src  (src),
    .start_len  (reg_wdata[LEN_W-1:0]),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_rerr   (mem_rerr),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_data    (st_data),
    .st_last    (st_last),
    .idle       (fetch_idle),
    .done_set   (done_set),
    .err_set    (err_set)
  );

endmodule

// File: rtl/rd_dma_chk.sv
module rd_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic [7:0]        st_data,
  input logic              st_last,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              run,
  input logic              srst,
  input logic              fetch_idle,
  input logic              done_set,
  input logic              err_set,
  input logic              done_flag,
  input logic              err_flag
);

  // R5: a stalled beat keeps its contents while no abort is pending
  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready && run && !srst) |=>
      (st_valid && $stable(st_data) && $stable(st_last)));

  // R5: an ungranted request keeps its address
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && run && !srst) |=> (mem_req && $stable(mem_addr)));

  // R4: accepting the final beat raises the completion flag
  p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_last && !srst) |=> done_flag);

  // R10: a faulty memory response raises the error flag
  p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set && !srst) |=> err_flag);

  // R2: a channel halted for two cycles issues no memory request
  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> !mem_req);

  // R11: soft reset finishes once the sequencer is idle, leaving it halted
  p_srst_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && fetch_idle) |=> (!srst && !run));

  // R4: completion and error pulses never coincide
  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_set && err_set));

endmodule

bind rd_dma_chan rd_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_data    (st_data),
  .st_last    (st_last),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .run        (ctrl.run),
  .srst       (srst),
  .fetch_idle (fetch_idle),
  .done_set   (done_set),
  .err_set    (err_set),
  .done_flag  (done_flag),
  .err_flag   (err_flag)
);

// File: tb/test_rd_dma_chan.sv
module test_rd_dma_chan;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [5:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic              reg_we = 1'b0;
  logic [31:0]       reg_rdata;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_gnt = 1'b1;
  logic              mem_rvalid = 1'b0;
  logic [7:0]        mem_rdata = '0;
  logic              mem_rerr = 1'b0;
  logic              st_valid;
  logic              st_ready = 1'b1;
  logic [7:0]        st_data;
  logic              st_last;
  logic              irq;

  int          applied = 0;
  int          miscompares = 0;
  int          beats = 0;
  logic [7:0]  got_data [256];
  logic        got_last [256];
  int          rdy_mode = 0;   // 0 always ready, 1 never, 2 alternate
  int          gnt_mode = 0;   // 0 always grant, 2 alternate
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  always #4 clk = ~clk;

  rd_dma_chan #(.ADDR_W(ADDR_W), .LEN_W(26)) i_rd_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .st_last(st_last), .irq(irq)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // memory model: one response the cycle after each grant
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_rerr   <= 1'b0;
    if (mem_req && mem_gnt) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= pat(mem_addr);
      mem_rerr   <= err_en && (mem_addr == err_addr);
    end
  end

  // stream monitor
  always @(posedge clk) begin
    if (st_valid && st_ready) begin
      got_data[beats % 256] <= st_data;
      got_last[beats % 256] <= st_last;
      beats <= beats + 1;
    end
  end

  // back-pressure and grant patterns
  always @(negedge clk) begin
    case (rdy_mode)
      0: st_ready = 1'b1;
      1: st_ready = 1'b0;
      default: st_ready = ~st_ready;
    endcase
    if (gnt_mode == 0) mem_gnt = 1'b1;
    else mem_gnt = ~mem_gnt;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(6'h04, s);
      if (s[1]) break;
    end
  endtask

  task automatic check_stream(input string tag, input int base, input int n,
                              input logic [31:0] src, input bit want_last);
    for (int i = 0; i < n; i++) begin
      chk({tag, " data"}, got_data[(base + i) % 256], pat(src + i));
      chk({tag, " last"}, got_last[(base + i) % 256], want_last && (i == n - 1));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(6'h04, d); chk("R1 status", d, 32'h3);
    chk("R1 irq", irq, 0);
    chk("R1 quiet", {st_valid, mem_req}, 2'b00);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    int base;
    wr(6'h00, 32'h1001);
    rd(6'h04, d); chk("R2 running", d, 32'h2);
    wr(6'h18, 32'h40);
    base = beats;
    wr(6'h28, 32'd5);
    rd(6'h04, d); chk("R4 busy", d[1], 0);
    wait_idle();
    chk("R3 count", beats - base, 5);
    check_stream("R3/R4", base, 5, 32'h40, 1);
    rd(6'h04, d); chk("R4 done flag", d, 32'h1002);
    chk("R7 irq done", irq, 1);
    wr(6'h04, 32'h1000);
    rd(6'h04, d); chk("R6 clear done", d, 32'h2);
    chk("R7 irq low", irq, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] d;
    int base;
    rdy_mode = 2; gnt_mode = 2;
    wr(6'h18, 32'hF0);
    base = beats;
    wr(6'h28, 32'd7);
    wait_idle();
    chk("R5 count", beats - base, 7);
    check_stream("R5", base, 7, 32'hF0, 1);
    wr(6'h04, 32'h1000);
    wr(6'h18, 32'h33);
    base = beats;
    wr(6'h28, 32'd1);
    wait_idle();
    chk("R4 single count", beats - base, 1);
    check_stream("R4 single", base, 1, 32'h33, 1);
    wr(6'h04, 32'h1000);
    rdy_mode = 0; gnt_mode = 0;
  endtask

  task automatic t_len_reject();
    logic [31:0] d;
    int base;
    wr(6'h00, 32'h4001);
    base = beats;
    wr(6'h28, 32'd0);
    repeat (4) @(negedge clk);
    rd(6'h04, d); chk("R8 zero len", d, 32'h4002);
    chk("R7 irq err", irq, 1);
    wr(6'h04, 32'h4000);
    rd(6'h04, d); chk("R6 clear err", d, 32'h2);
    wr(6'h28, 32'h0400_0000);
    repeat (4) @(negedge clk);
    rd(6'h04, d); chk("R8 wide len", d, 32'h4002);
    chk("R8 no beats", beats - base, 0);
    rd(6'h28, d); chk("R8 len kept", d, 32'd1);
    wr(6'h18, 32'h10);
    wr(6'h28, 32'd2);
    wait_idle();
    rd(6'h04, d); chk("R6 both set", d, 32'h5002);
    wr(6'h04, 32'h1000);
    rd(6'h04, d); chk("R6 only done", d, 32'h4002);
    wr(6'h28, 32'd2);
    wait_idle();
    wr(6'h04, 32'h4000);
    rd(6'h04, d); chk("R6 only err", d, 32'h1002);
    chk("R7 done masked", irq, 0);
    wr(6'h04, 32'h0);
    rd(6'h04, d); chk("R6 zero write", d, 32'h1002);
    wr(6'h04, 32'h1000);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    int base;
    wr(6'h00, 32'h0);
    base = beats;
    wr(6'h28, 32'd3);
    repeat (8) @(negedge clk);
    rd(6'h04, d); chk("R9 halted ignore", d, 32'h3);
    chk("R9 halted no beats", beats - base, 0);
    rd(6'h28, d); chk("R9 halted len kept", d, 32'd2);
    wr(6'h00, 32'h1);
    rdy_mode = 1;
    wr(6'h18, 32'h60);
    wr(6'h28, 32'd4);
    wr(6'h28, 32'd9);
    rdy_mode = 0;
    wait_idle();
    chk("R9 busy count", beats - base, 4);
    check_stream("R9", base, 4, 32'h60, 1);
    rd(6'h28, d); chk("R9 busy len kept", d, 32'd4);
    wr(6'h04, 32'h1000);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    int base, n;
    bit seen_last;
    rdy_mode = 2;
    wr(6'h18, 32'h0);
    base = beats;
    wr(6'h28, 32'd20);
    repeat (12) @(negedge clk);
    wr(6'h00, 32'h0);
    repeat (10) @(negedge clk);
    n = beats - base;
    repeat (20) @(negedge clk);
    chk("R2 no more beats", beats - base, n);
    chk("R2 partial", n < 20, 1);
    rd(6'h04, d); chk("R2 halted idle", d, 32'h3);
    seen_last = 0;
    for (int i = 0; i < n; i++) seen_last |= got_last[(base + i) % 256];
    chk("R2 no last", seen_last, 0);
    rdy_mode = 0;
  endtask

  task automatic t_memerr();
    logic [31:0] d;
    int base;
    wr(6'h00, 32'h4001);
    err_en = 1'b1; err_addr = 32'h83;
    wr(6'h18, 32'h80);
    base = beats;
    wr(6'h28, 32'd8);
    wait_idle();
    err_en = 1'b0;
    chk("R10 count", beats - base, 3);
    check_stream("R10", base, 3, 32'h80, 0);
    rd(6'h04, d); chk("R10 status", d, 32'h4002);
    chk("R10 irq", irq, 1);
    wr(6'h04, 32'h4000);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(6'h00, 32'h5001);
    rdy_mode = 1;
    wr(6'h18, 32'h55);
    wr(6'h28, 32'd3);
    repeat (4) @(negedge clk);
    wr(6'h00, 32'h4);
    rd(6'h00, d); chk("R11 in progress", d[2], 1);
    repeat (6) @(negedge clk);
    rd(6'h00, d); chk("R11 ctrl", d, 32'h0);
    rd(6'h04, d); chk("R11 status", d, 32'h3);
    rd(6'h18, d); chk("R11 src", d, 32'h0);
    rd(6'h28, d); chk("R11 len", d, 32'h0);
    chk("R11 irq", irq, 0);
    rdy_mode = 0;
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(6'h30, 32'hFFFF_FFFF);
    wr(6'h2C, 32'h1001);
    rd(6'h30, d); chk("R12 0x30", d, 32'h0);
    rd(6'h2C, d); chk("R12 0x2c", d, 32'h0);
    rd(6'h00, d); chk("R12 ctrl untouched", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_len_reject();
    t_ignored();
    t_abort();
    t_memerr();
    t_srst();
    t_window();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied + 1, miscompares + 1);
    $finish;
  end

endmodule